// File: doc/BRIEF.md
# Bit-Serial Adder with Set/Reset Carry

This block adds two unsigned operands of `WIDTH` bits by walking through them one bit pair per clock, starting from the least significant bit. The operands are captured in parallel into two right-shifting registers. The sum is collected serially into a third register whose serial input is its top bit, so after the last shift the word is in its natural order. The carry between bit positions lives in a single state bit. That bit is not recomputed every cycle. It is driven only by a generate condition (both bits 1), which sets it, and a kill condition (both bits 0), which clears it. In every other cycle it holds.

A host presents both operands with a load strobe, then pulses start. After a fixed latency a one-cycle done pulse marks that the parallel sum and the carry-out are valid. Both values hold until the next load or accepted start. A start strobe that arrives while an addition is running is ignored. A load aborts any running addition.

Top module: `serial_adder_sr`

## Requirements
- R1: Bit pairs are consumed least significant first, one per clock. An accepted start (start_i high while idle, with load_i low) raises done_o at the WIDTH+1-th rising edge after the accepting edge, counting the accepting edge as edge 0.
- R2: A bit pair with both bits 1 sets the carry bit for the next position. For example, 0xFF + 0xFF gives sum 0xFE and carry-out 1.
- R3: A bit pair with both bits 0 clears the carry bit. For example, 0x01 + 0x01 gives sum 0x02 and carry-out 0.
- R4: A bit pair with exactly one bit 1 keeps the carry bit unchanged. For example, 0xFF + 0x01 carries through every position and gives sum 0x00 and carry-out 1.
- R5: Each sum bit is the XOR of both operand bits and the stored carry. While done_o is high, sum_o equals (A+B) mod 2^WIDTH.
- R6: While done_o is high, cout_o equals bit WIDTH of A+B.
- R7: A rising edge with load_i high captures opa_i and opb_i and clears the carry, the sum register and the bit counter. Load takes priority over start in the same cycle (that start is ignored) and aborts a running addition, so no done_o follows until a new start.
- R8: done_o is high for exactly one cycle. After it, sum_o and cout_o keep their values until the next load or accepted start.
- R9: A start strobe while an addition is running is ignored. done_o still comes at the time set by the first start, and the result is unchanged.
- R10: A rising edge with rst high clears every state element: done_o, sum_o and cout_o read 0 afterwards.
- R11: An accepted start clears the carry bit. The operand registers shift in zeros, so a second start without a new load yields sum 0 and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture both operands, clear carry, sum and counter |
| opa_i | input | WIDTH | Operand A, parallel |
| opb_i | input | WIDTH | Operand B, parallel |
| start_i | input | 1 | Begin an addition when idle |
| done_o | output | 1 | One-cycle pulse: result valid |
| sum_o | output | WIDTH | Parallel sum |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
A carry bit that sets, clears or holds at the wrong moment corrupts the very next sum bit. This shows at sum_o on the done pulse as a wrong word for operands with long propagate runs, such as all-ones plus one. A counter that is off by one moves done_o away from its fixed latency of WIDTH+1 edges, which is visible in the first addition. Control faults show within one addition: a start that is not ignored, a load that does not abort, or a carry that is not cleared on start. Each appears as a shifted or missing done pulse or a non-zero repeat result.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [0:0] {
        SA_IDLE = 1'b0,
        SA_RUN  = 1'b1
    } sa_state_e;
endpackage

// File: rtl/sa_shreg.sv
// Parallel-load right shift register with a serial input at the top bit.
module sa_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    logic [W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (load) begin
            reg_d = load_val;
        end else if (shift) begin
            if (W > 1) begin
                reg_d = {ser_in, reg_q[W-1:1]};
            end else begin
                reg_d = ser_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign q = reg_q;
endmodule

// File: rtl/sa_carry_cell.sv
// Carry state bit driven only by generate (set) and kill (clear).
module sa_carry_cell (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic abit,
    input  logic bbit,
    output logic carry
);
    logic carry_d, carry_q;
    logic gen_bit, kill_bit;

    assign gen_bit  = abit & bbit;
    assign kill_bit = ~abit & ~bbit;

    always_comb begin
        carry_d = carry_q;
        if (clr) begin
            carry_d = 1'b0;
        end else if (en && gen_bit) begin
            carry_d = 1'b1;
        end else if (en && kill_bit) begin
            carry_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= carry_d;
        end
    end

    assign carry = carry_q;
endmodule

// File: rtl/sa_ctrl.sv
// Sequencer: idle/run state, bit counter, done pulse.
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int W = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic start,
    output logic shift_en,
    output logic clr_carry,
    output logic done
);
    typedef struct packed {
        sa_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    ctrl_t ctl_d, ctl_q;
    logic  accept;

    assign accept = (ctl_q.state == SA_IDLE) && start && !load;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        shift_en   = 1'b0;
        if (load) begin
            ctl_d.state = SA_IDLE;
            ctl_d.cnt   = '0;
        end else begin
            unique case (ctl_q.state)
                SA_IDLE: begin
                    if (start) begin
                        ctl_d.state = SA_RUN;
                        ctl_d.cnt   = '0;
                    end
                end
                SA_RUN: begin
                    shift_en = 1'b1;
                    if (ctl_q.cnt == LAST) begin
                        ctl_d.state = SA_IDLE;
                        ctl_d.cnt   = '0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                default: ctl_d.state = SA_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: SA_IDLE, cnt: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clr_carry = load | accept;
    assign done      = ctl_q.done;
endmodule

// File: rtl/serial_adder_sr.sv
module serial_adder_sr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             start_i,
    output logic             done_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NOPS = 2;

    logic [NOPS-1:0][WIDTH-1:0] op_load;
    logic [NOPS-1:0][WIDTH-1:0] op_q;
    logic                       shift_en;
    logic                       clr_carry;
    logic                       carry_q;
    logic                       a_lsb, b_lsb, sum_bit;

    assign op_load[0] = opa_i;
    assign op_load[1] = opb_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        sa_shreg #(.W(WIDTH)) u_op (
            .clk      (clk),
            .rst      (rst),
            .load     (load_i),
            .load_val (op_load[g]),
            .shift    (shift_en),
            .ser_in   (1'b0),
            .q        (op_q[g])
        );
    end

    assign a_lsb   = op_q[0][0];
    assign b_lsb   = op_q[1][0];
    assign sum_bit = a_lsb ^ b_lsb ^ carry_q;

    sa_shreg #(.W(WIDTH)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .load_val ('0),
        .shift    (shift_en),
        .ser_in   (sum_bit),
        .q        (sum_o)
    );

    sa_carry_cell u_carry (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_carry),
        .en    (shift_en),
        .abit  (a_lsb),
        .bbit  (b_lsb),
        .carry (carry_q)
    );

    sa_ctrl #(.W(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (load_i),
        .start     (start_i),
        .shift_en  (shift_en),
        .clr_carry (clr_carry),
        .done      (done_o)
    );

    assign cout_o = carry_q;
endmodule

// File: rtl/sa_checker.sv
module sa_checker (
    input logic clk,
    input logic rst,
    input logic load,
    input logic shift,
    input logic abit,
    input logic bbit,
    input logic carry,
    input logic sum_msb,
    input logic done
);
    AST_CARRY_GEN: assert property (@(posedge clk) disable iff (rst)
        (shift && abit && bbit && !load) |=> carry); // R2
    AST_CARRY_KILL: assert property (@(posedge clk) disable iff (rst)
        (shift && !abit && !bbit) |=> !carry); // R3
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (shift && (abit ^ bbit) && !load) |=> $stable(carry)); // R4
    AST_SUM_BIT: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (sum_msb == ($past(abit) ^ $past(bbit) ^ $past(carry)))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        load |=> (!carry && !done)); // R7
endmodule

bind serial_adder_sr sa_checker u_sa_checker (
    .clk     (clk),
    .rst     (rst),
    .load    (load_i),
    .shift   (shift_en),
    .abit    (a_lsb),
    .bbit    (b_lsb),
    .carry   (carry_q),
    .sum_msb (sum_o[WIDTH-1]),
    .done    (done_o)
);

// File: tb/serial_adder_sr_bench.sv
`timescale 1ns/1ps
module serial_adder_sr_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         done_o;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_adder_sr #(.WIDTH(W)) u_serial_adder_sr (
        .clk(clk), .rst(rst), .load_i(load_i), .opa_i(opa_i), .opb_i(opb_i),
        .start_i(start_i), .done_o(done_o), .sum_o(sum_o), .cout_o(cout_o)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        opa_i = a; opb_i = b; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Pulses start, returns number of negedges until done (0 if none).
    task automatic run_start(output int lat, input int extra_start_at);
        int n = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        while (!done_o && n < W + 6) begin
            @(negedge clk);
            n++;
            if (n == extra_start_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        lat = done_o ? n : 0;
    endtask

    task automatic add_check(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        int lat;
        logic [W:0] exp;
        exp = ref_add(a, b);
        do_load(a, b);
        run_start(lat, 0);
        check({tag, " R1 latency"}, (W+1)'(lat), (W+1)'(W + 1));
        check({tag, " R5 sum"}, {1'b0, sum_o}, {1'b0, exp[W-1:0]});
        check({tag, " R6 cout"}, {{W{1'b0}}, cout_o}, {{W{1'b0}}, exp[W]});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [W:0] exp;
        logic [W-1:0] held_sum;
        logic held_cout;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 done", {{W{1'b0}}, done_o}, '0);
        check("R10 sum", {1'b0, sum_o}, '0);
        check("R10 cout", {{W{1'b0}}, cout_o}, '0);

        // Directed corners
        add_check(8'h00, 8'h00, "zeros R3");
        add_check(8'hFF, 8'hFF, "ones R2");
        add_check(8'h01, 8'h01, "kill R3");
        add_check(8'hFF, 8'h01, "propagate R4");
        add_check(8'hAA, 8'h55, "alternate R4");
        add_check(8'h80, 8'h80, "top R2");

        // R8: outputs hold after done, done pulse ends
        held_sum = sum_o; held_cout = cout_o;
        repeat (3) @(negedge clk);
        check("R8 done low", {{W{1'b0}}, done_o}, '0);
        check("R8 sum hold", {1'b0, sum_o}, {1'b0, held_sum});
        check("R8 cout hold", {{W{1'b0}}, cout_o}, {{W{1'b0}}, held_cout});

        // R11: second start without load gives zero result
        add_check(8'hF0, 8'h1F, "pre R11");
        run_start(lat, 0);
        check("R11 latency", (W+1)'(lat), (W+1)'(W + 1));
        check("R11 sum", {1'b0, sum_o}, '0);
        check("R11 cout", {{W{1'b0}}, cout_o}, '0);

        // R9: extra start during run is ignored
        do_load(8'hC3, 8'h7E);
        exp = ref_add(8'hC3, 8'h7E);
        run_start(lat, 3);
        check("R9 latency", (W+1)'(lat), (W+1)'(W + 1));
        check("R9 sum", {1'b0, sum_o}, {1'b0, exp[W-1:0]});
        check("R9 cout", {{W{1'b0}}, cout_o}, {{W{1'b0}}, exp[W]});
        repeat (W + 3) @(negedge clk);
        check("R9 no second done", {{W{1'b0}}, done_o}, '0);

        // R7: load aborts a running addition
        do_load(8'h12, 8'h34);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        lat = 0;
        opa_i = 8'hFF; opb_i = 8'hFF; load_i = 1'b1;
        @(negedge clk); load_i = 1'b0;
        check("R7 cleared sum", {1'b0, sum_o}, '0);
        check("R7 cleared carry", {{W{1'b0}}, cout_o}, '0);
        for (int i = 0; i < W + 4; i++) begin
            if (done_o) lat = 1;
            @(negedge clk);
        end
        check("R7 abort no done", (W+1)'(lat), '0);

        // R7: load and start in the same cycle, start ignored
        @(negedge clk);
        opa_i = 8'h01; opb_i = 8'h02; load_i = 1'b1; start_i = 1'b1;
        @(negedge clk); load_i = 1'b0; start_i = 1'b0;
        lat = 0;
        for (int i = 0; i < W + 4; i++) begin
            if (done_o) lat = 1;
            @(negedge clk);
        end
        check("R7 load priority", (W+1)'(lat), '0);
        run_start(lat, 0);
        check("R7 sum after load", {1'b0, sum_o}, 9'h003);

        // Random operands
        for (int k = 0; k < 200; k++) begin
            add_check(W'($urandom), W'($urandom), "random R5");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule